// File: doc/BRIEF.md
# Dual-Edge Alarm Interrupt Controller

This block sits beside the receive side of a DS3/E3 framer. It watches six level-type alarm conditions: out of frame, AIS, remote alarm (yellow), idle, loss of signal and severely errored frame. It catches both edges of each one. A condition turning on sets a bit in a start-status register. A condition turning off sets a bit in a separate end-status register. Two enable registers choose which of those recorded edges may pull the shared active-low interrupt line.

Software reaches the four registers through a small single-cycle register port. Writes take effect on the next clock edge. Reads are combinational on the address. Status bits stay set until software writes a 1 to them. A line-mode input chooses DS3 or one of two E3 framings. The severely-errored-frame and idle alarms exist only in DS3, so in either E3 mode they are held out of both status and interrupt.

Top module: `alarm_edge_intc`

## Requirements
- R1: After reset, all four registers read 0x00 and `intN` is high.
- R2: Both enable registers can be written and read back at any time. Address 0 is the start-enable register and address 1 is the end-enable register. The bit layout is the same in every register: bit 5 severely errored frame, bit 4 loss of signal, bit 3 idle, bit 2 yellow, bit 1 AIS, bit 0 OOF.
- R3: Each alarm input is registered once. A 0-to-1 change of the registered value between consecutive clocks sets the matching start-status bit (address 2), whether or not its enable is set. The bit reads as set two clock edges after the input changes.
- R4: A 1-to-0 change of the registered alarm sets the matching end-status bit (address 3), whether or not its enable is set.
- R5: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge of the same kind arrives in the same cycle as the clear, the bit stays set.
- R6: `intN` is low whenever any status bit is set while its matching enable bit is set, and it is high otherwise. Setting or clearing an enable changes `intN` in the cycle after the write.
- R7: `modeSel` 2'b00 selects DS3, and any other value selects E3. In E3, edges on bits 5 and 3 set no status bit, and those two bits do not take part in `intN`, even when they were set earlier. Bits 4, 2, 1 and 0 behave the same in every mode.
- R8: Bits 7 and 6 of every register read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alarmIn | input | 6 | Alarm levels from the framer, using the bit layout of R2 |
| modeSel | input | 2 | Line mode: 00 selects DS3, any other value selects E3 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 start enable, 1 end enable, 2 start status, 3 end status |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| intN | output | 1 | Interrupt, active low |

## Verification
Two things can fall in the same cycle: a software clear of a status bit, and a new edge of the same kind on that bit. The bench forces the overlap on the loss-of-signal bit. It first leaves the start bit set and the alarm low. It then raises the alarm at one falling clock edge and drives the write-1 clear at the next, so the clear lands on the very clock that records the new start. The bit must still read as set afterwards. A clear on its own, a few cycles later, must then empty it.

// File: rtl/alarm_intc_pkg.sv
package alarm_intc_pkg;

  localparam int ALARM_CNT = 6;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_START_EN  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_END_EN    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_START_STS = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_END_STS   = 2'd3;

  // Alarms that exist only on DS3 lines: severely errored frame (5), idle (3)
  localparam logic [ALARM_CNT-1:0] DS3_ONLY_MASK = 6'b101000;

  typedef enum logic [1:0] {
    MODE_DS3   = 2'b00,
    MODE_E3_A  = 2'b01,
    MODE_E3_B  = 2'b10,
    MODE_E3_X  = 2'b11
  } line_mode_e;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic                 loadStartEn;
    logic                 loadEndEn;
    logic                 clrStartSts;
    logic                 clrEndSts;
    logic [ALARM_CNT-1:0] bits;
  } reg_strobe_t;

endpackage

// File: rtl/alarm_intc_ctrl.sv
module alarm_intc_ctrl
  import alarm_intc_pkg::*;
(
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [ALARM_CNT-1:0] startEn,
  input  logic [ALARM_CNT-1:0] endEn,
  input  logic [ALARM_CNT-1:0] startSts,
  input  logic [ALARM_CNT-1:0] endSts,
  output reg_strobe_t          strobe,
  output logic [REG_W-1:0]     regRdData
);

  // Reserved write bits are dropped here
  logic unusedWrHigh;
  assign unusedWrHigh = ^regWrData[REG_W-1:ALARM_CNT];

  always_comb begin
    strobe      = '0;
    strobe.bits = regWrData[ALARM_CNT-1:0];
    if (regWrEn) begin
      case (regAddr)
        ADDR_START_EN:  strobe.loadStartEn = 1'b1;
        ADDR_END_EN:    strobe.loadEndEn   = 1'b1;
        ADDR_START_STS: strobe.clrStartSts = 1'b1;
        ADDR_END_STS:   strobe.clrEndSts   = 1'b1;
        default:        ;
      endcase
    end
  end

  // Reads are combinational; upper bits stay zero
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_START_EN:  regRdData[ALARM_CNT-1:0] = startEn;
      ADDR_END_EN:    regRdData[ALARM_CNT-1:0] = endEn;
      ADDR_START_STS: regRdData[ALARM_CNT-1:0] = startSts;
      ADDR_END_STS:   regRdData[ALARM_CNT-1:0] = endSts;
      default:        ;
    endcase
  end

endmodule

// File: rtl/alarm_intc_datapath.sv
module alarm_intc_datapath
  import alarm_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ALARM_CNT-1:0] alarmIn,
  input  logic [1:0]           modeSel,
  input  reg_strobe_t          strobe,
  output logic [ALARM_CNT-1:0] startEn,
  output logic [ALARM_CNT-1:0] endEn,
  output logic [ALARM_CNT-1:0] startSts,
  output logic [ALARM_CNT-1:0] endSts,
  output logic                 intN
);

  logic [ALARM_CNT-1:0] liveMask;
  logic [ALARM_CNT-1:0] pendVec;

  // E3 framings drop the DS3-only alarms
  always_comb begin
    if (modeSel == MODE_DS3) liveMask = '1;
    else                     liveMask = ~DS3_ONLY_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   startEn <= '0;
    else if (strobe.loadStartEn) startEn <= strobe.bits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 endEn <= '0;
    else if (strobe.loadEndEn) endEn <= strobe.bits;
  end

  for (genvar i = 0; i < ALARM_CNT; i++) begin : g_alarm
    logic syncQ;
    logic prevQ;
    logic riseEv;
    logic fallEv;
    logic startBit;
    logic endBit;
    logic clrStart;
    logic clrEnd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= alarmIn[i];
        prevQ <= syncQ;
      end
    end

    assign riseEv   = syncQ & ~prevQ & liveMask[i];
    assign fallEv   = ~syncQ & prevQ & liveMask[i];
    assign clrStart = strobe.clrStartSts & strobe.bits[i];
    assign clrEnd   = strobe.clrEndSts & strobe.bits[i];

    // A fresh edge outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startBit <= 1'b0;
        endBit   <= 1'b0;
      end else begin
        startBit <= (startBit & ~clrStart) | riseEv;
        endBit   <= (endBit & ~clrEnd) | fallEv;
      end
    end

    assign startSts[i] = startBit;
    assign endSts[i]   = endBit;
  end

  assign pendVec = ((startSts & startEn) | (endSts & endEn)) & liveMask;
  assign intN    = ~|pendVec;

endmodule

// File: rtl/alarm_edge_intc.sv
module alarm_edge_intc
  import alarm_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ALARM_CNT-1:0] alarmIn,
  input  logic [1:0]           modeSel,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 intN
);

  reg_strobe_t          strobe;
  logic [ALARM_CNT-1:0] startEn;
  logic [ALARM_CNT-1:0] endEn;
  logic [ALARM_CNT-1:0] startSts;
  logic [ALARM_CNT-1:0] endSts;

  alarm_intc_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .startEn   (startEn),
    .endEn     (endEn),
    .startSts  (startSts),
    .endSts    (endSts),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  alarm_intc_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .alarmIn  (alarmIn),
    .modeSel  (modeSel),
    .strobe   (strobe),
    .startEn  (startEn),
    .endEn    (endEn),
    .startSts (startSts),
    .endSts   (endSts),
    .intN     (intN)
  );

endmodule

// File: rtl/alarm_intc_checker.sv
module alarm_intc_checker
  import alarm_intc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [ALARM_CNT-1:0] enData,
  input logic [REG_W-1:0]     regRdData,
  input logic [1:0]           modeSel,
  input logic                 intN,
  input logic [ALARM_CNT-1:0] startEn,
  input logic [ALARM_CNT-1:0] startSts,
  input logic [ALARM_CNT-1:0] endSts
);

  assert_en_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_START_EN) |=> (startEn == $past(enData)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((|($past(startSts) & ~startSts)) |-> $past(regWrEn && regAddr == ADDR_START_STS)));

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startSts == '0 && endSts == '0) |-> intN);

  assert_irq_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((startSts & startEn & ~DS3_ONLY_MASK) != '0) |-> !intN);

  assert_e3_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_DS3) |=>
      (((startSts & ~$past(startSts)) | (endSts & ~$past(endSts))) & DS3_ONLY_MASK) == '0);

  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:ALARM_CNT] == '0);

endmodule

bind alarm_edge_intc alarm_intc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .enData    (regWrData[alarm_intc_pkg::ALARM_CNT-1:0]),
  .regRdData (regRdData),
  .modeSel   (modeSel),
  .intN      (intN),
  .startEn   (startEn),
  .startSts  (startSts),
  .endSts    (endSts)
);

// File: tb/alarm_edge_intc_bench.sv
`timescale 1ns/1ps
module alarm_edge_intc_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] alarmIn = '0;
  logic [1:0] modeSel = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       intN;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  alarm_edge_intc u_alarm_edge_intc (
    .clk       (clk),
    .rstN      (rstN),
    .alarmIn   (alarmIn),
    .modeSel   (modeSel),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .intN      (intN)
  );

  typedef struct packed {
    logic [5:0] alarm;
    logic [1:0] mode;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] data;
    logic [5:0] expStart;
    logic [5:0] expEnd;
    logic       expIntN;
  } vec_t;

  // Each step: apply alarm/mode/optional write, settle three clocks, check
  localparam vec_t VEC [19] = '{
    '{6'h01, 2'd0, 1'b0, 2'd0, 8'h00, 6'h01, 6'h00, 1'b1},
    '{6'h01, 2'd0, 1'b1, 2'd0, 8'h01, 6'h01, 6'h00, 1'b0},
    '{6'h00, 2'd0, 1'b0, 2'd0, 8'h00, 6'h01, 6'h01, 1'b0},
    '{6'h00, 2'd0, 1'b1, 2'd2, 8'h01, 6'h00, 6'h01, 1'b1},
    '{6'h00, 2'd0, 1'b1, 2'd1, 8'h3F, 6'h00, 6'h01, 1'b0},
    '{6'h00, 2'd0, 1'b1, 2'd3, 8'hFF, 6'h00, 6'h00, 1'b1},
    '{6'h28, 2'd0, 1'b0, 2'd0, 8'h00, 6'h28, 6'h00, 1'b1},
    '{6'h00, 2'd0, 1'b0, 2'd0, 8'h00, 6'h28, 6'h28, 1'b0},
    '{6'h00, 2'd0, 1'b1, 2'd3, 8'h28, 6'h28, 6'h00, 1'b1},
    '{6'h00, 2'd0, 1'b1, 2'd2, 8'h28, 6'h00, 6'h00, 1'b1},
    '{6'h2C, 2'd1, 1'b0, 2'd0, 8'h00, 6'h04, 6'h00, 1'b1},
    '{6'h00, 2'd1, 1'b0, 2'd0, 8'h00, 6'h04, 6'h04, 1'b0},
    '{6'h00, 2'd2, 1'b1, 2'd3, 8'h04, 6'h04, 6'h00, 1'b1},
    '{6'h00, 2'd2, 1'b1, 2'd0, 8'h3F, 6'h04, 6'h00, 1'b0},
    '{6'h00, 2'd0, 1'b1, 2'd2, 8'h04, 6'h00, 6'h00, 1'b1},
    '{6'h20, 2'd0, 1'b0, 2'd0, 8'h00, 6'h20, 6'h00, 1'b0},
    '{6'h20, 2'd1, 1'b0, 2'd0, 8'h00, 6'h20, 6'h00, 1'b1},
    '{6'h20, 2'd0, 1'b0, 2'd0, 8'h00, 6'h20, 6'h00, 1'b0},
    '{6'h20, 2'd0, 1'b1, 2'd2, 8'h20, 6'h00, 6'h00, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = addr;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] addr, output logic [7:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check("R1 register after reset", rd, 8'h00);
    end
    check("R1 intN after reset", {7'd0, intN}, 8'h01);

    // Table walk: R3 R4 R5 R6 R7
    for (int k = 0; k < 19; k++) begin
      @(negedge clk);
      alarmIn = VEC[k].alarm;
      modeSel = VEC[k].mode;
      regWrEn = VEC[k].wr;
      regAddr = VEC[k].addr;
      regWrData = VEC[k].data;
      @(negedge clk);
      regWrEn = 1'b0;
      repeat (2) @(negedge clk);
      regRead(2'd2, rd);
      check($sformatf("R3/R5/R7 start status step %0d", k), rd, {2'b00, VEC[k].expStart});
      regRead(2'd3, rd);
      check($sformatf("R4/R5/R7 end status step %0d", k), rd, {2'b00, VEC[k].expEnd});
      check($sformatf("R6/R7 intN step %0d", k), {7'd0, intN}, {7'd0, VEC[k].expIntN});
    end

    // Fresh reset for directed tests
    @(negedge clk);
    alarmIn = '0;
    modeSel = 2'd0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(2'd0, rd);
    check("R1 start enable after second reset", rd, 8'h00);

    // R2 and R8: readback, reserved bits masked
    regWrite(2'd0, 8'hFF);
    regRead(2'd0, rd);
    check("R2/R8 start enable readback", rd, 8'h3F);
    regWrite(2'd1, 8'hC5);
    regRead(2'd1, rd);
    check("R2/R8 end enable readback", rd, 8'h05);
    regWrite(2'd0, 8'h00);
    regRead(2'd0, rd);
    check("R2 start enable rewrite", rd, 8'h00);

    // R5: writing zero leaves a status bit alone
    @(negedge clk);
    alarmIn = 6'h10;
    settle();
    regWrite(2'd2, 8'h00);
    regRead(2'd2, rd);
    check("R5 zero write keeps start status", rd, 8'h10);

    // R5: clear and new start on the same clock
    alarmIn = 6'h00;
    settle();
    regRead(2'd3, rd);
    check("R4 loss of signal end status", rd, 8'h10);
    @(negedge clk);
    alarmIn = 6'h10;
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = 2'd2;
    regWrData = 8'h10;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (2) @(negedge clk);
    regRead(2'd2, rd);
    check("R5 edge wins over same-cycle clear", rd, 8'h10);
    regWrite(2'd2, 8'h10);
    regRead(2'd2, rd);
    check("R5 plain clear empties start status", rd, 8'h00);

    // R6: enabling after the fact pulls intN, disabling releases it
    check("R6 intN high with end status unenabled", {7'd0, intN}, 8'h01);
    regWrite(2'd1, 8'h10);
    check("R6 late enable asserts intN", {7'd0, intN}, 8'h00);
    regWrite(2'd1, 8'h00);
    check("R6 disable releases intN", {7'd0, intN}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule